// File: doc/BRIEF.md
# Predicate and Poison Issue Qualifier

This unit sits at the issue stage of a statically scheduled core. It decides whether each operation really takes effect. It holds a file of one-bit predicate registers and a poison bit for every general register. Every incoming operation names a guarding predicate. When that predicate reads false, the operation is turned into a no-op: it writes nothing, raises nothing and changes no state. A compare operation writes its boolean result into one predicate destination and the inverse into a second destination. These predicates then steer later guarded operations.

Poison bits let a scheduler hoist a load above a branch. A speculative load that hits a fault does not trap. It marks its destination register as poisoned instead. A later check operation on that register sends control to a fixup address, but only when the poison bit is set. A non-speculative load that faults raises an exception straight away. Any ordinary write to a register clears that register's poison bit. Fault status comes in with the operation. Memory, fetch and the execution units sit outside this unit.

Operations arrive on a valid/ready stream. `op_ready` is held high, so the unit never applies back-pressure: every cycle with `op_valid` high consumes exactly one operation. All results are registered and appear on the outputs in the cycle after the operation is accepted. Two read-back ports show one predicate and one poison bit combinationally.

Top module: `pred_issue_unit`

## Requirements
- R1: There are 64 one-bit predicate registers, read through `pred_rd_idx`/`pred_rd_val`. After reset every entry reads 0 except entry 0, and all 32 poison bits (read through `psn_rd_idx`/`psn_rd_val`) read 0.
- R2: A compare (`op_kind`=2) that is not squashed writes `op_cmp_res` into predicate `op_pd1` and its inverse into predicate `op_pd2`. The new values are visible on read-back once the accepting clock edge has passed. If `op_pd1` equals `op_pd2`, the inverse is what remains.
- R3: Predicate 0 always reads 1, and writes aimed at it have no effect.
- R4: An operation whose guard predicate `op_guard` reads 0 is squashed. In the following cycle `out_fire`, `out_wen`, `out_exc` and `out_redir` are all 0, and no predicate or poison bit changes.
- R5: A speculative load (`op_kind`=4) that is not squashed sets poison[`op_rd`] to `op_fault`, asserts `out_wen` with `out_wreg`=`op_rd`, and never asserts `out_exc`.
- R6: A normal load (`op_kind`=3) that is not squashed behaves as follows. With `op_fault`=1 it asserts `out_exc`, keeps `out_wen` low and leaves the poison bit unchanged. With `op_fault`=0 it asserts `out_wen` and clears poison[`op_rd`].
- R7: An ALU write (`op_kind`=1) that is not squashed asserts `out_wen` with `out_wreg`=`op_rd` and clears poison[`op_rd`].
- R8: A check (`op_kind`=5) that is not squashed, on a register whose poison bit is set, asserts `out_redir` with `out_redir_pc`=`op_fixup`. On a register with a clear poison bit it does not redirect. In both cases the poison bit is left unchanged.
- R9: `op_ready` is always 1. Outputs are registered one cycle after acceptance, and `out_fire` is 1 exactly when a valid operation was not squashed. A cycle with `op_valid` low produces no output activity. Kinds 0, 6 and 7 fire but change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Always 1, no back-pressure |
| op_kind | input | 3 | 0 nop, 1 ALU write, 2 compare, 3 load, 4 speculative load, 5 check |
| op_guard | input | 6 | Guarding predicate index |
| op_pd1 | input | 6 | Compare destination for the result |
| op_pd2 | input | 6 | Compare destination for the inverse |
| op_cmp_res | input | 1 | Compare outcome |
| op_rd | input | 5 | Destination or checked register |
| op_fault | input | 1 | Fault status for loads |
| op_fixup | input | 32 | Fixup address for checks |
| out_fire | output | 1 | Previous operation took effect |
| out_wen | output | 1 | Register write enable |
| out_wreg | output | 5 | Register being written |
| out_exc | output | 1 | Immediate load exception |
| out_redir | output | 1 | Redirect to fixup code |
| out_redir_pc | output | 32 | Fixup target |
| pred_rd_idx | input | 6 | Predicate read-back index |
| pred_rd_val | output | 1 | Predicate read-back value |
| psn_rd_idx | input | 5 | Poison read-back index |
| psn_rd_val | output | 1 | Poison read-back value |

## Verification
The bench drives every kind of operation under both guard values and both fault values, with the target register first poisoned and then clean. A design that lets a squashed faulting load through would either raise a spurious exception or poison a register. A design that drops the squash on checks would redirect with no cause. Compares aimed at predicate 0 catch any design that lets entry 0 become false and so stalls every unguarded operation. Compares with both destinations equal catch a design with the wrong write order. A long pseudo-random run against an arithmetic model finds poison that is not cleared by ordinary writes, or that is wrongly cleared by checks.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [2:0] {
    K_NOP  = 3'd0,
    K_ALU  = 3'd1,
    K_CMP  = 3'd2,
    K_LD   = 3'd3,
    K_LDS  = 3'd4,
    K_CHK  = 3'd5,
    K_RSV6 = 3'd6,
    K_RSV7 = 3'd7
  } op_kind_e;
endpackage

// File: rtl/pq_pred_file.sv
module pq_pred_file #(
  parameter int NPRED = 64,
  localparam int IW = $clog2(NPRED)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] guard_idx,
  output logic          guard_ok,
  input  logic          we,
  input  logic [IW-1:0] wa_a,
  input  logic          wd_a,
  input  logic [IW-1:0] wa_b,
  input  logic          wd_b,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_val
);
  logic [NPRED-1:0] bits;

  assign bits[0] = 1'b1;

  for (genvar i = 1; i < NPRED; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        bits[i] <= 1'b0;
      else if (we && wa_b == IW'(i))
        bits[i] <= wd_b;
      else if (we && wa_a == IW'(i))
        bits[i] <= wd_a;
    end
  end

  assign guard_ok = bits[guard_idx];
  assign rd_val   = bits[rd_idx];
endmodule

// File: rtl/pq_poison_file.sv
module pq_poison_file #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [RW-1:0] upd_idx,
  input  logic          upd_val,
  input  logic [RW-1:0] look_idx,
  output logic          look_val,
  input  logic [RW-1:0] dbg_idx,
  output logic          dbg_val
);
  logic [NREG-1:0] psn;

  for (genvar i = 0; i < NREG; i++) begin : g_psn
    always_ff @(posedge clk) begin
      if (!rst_n)
        psn[i] <= 1'b0;
      else if (upd && upd_idx == RW'(i))
        psn[i] <= upd_val;
    end
  end

  assign look_val = psn[look_idx];
  assign dbg_val  = psn[dbg_idx];
endmodule

// File: rtl/pred_issue_unit.sv
module pred_issue_unit #(
  parameter int NPRED = 64,
  parameter int NREG  = 32,
  parameter int PC_W  = 32,
  localparam int PW = $clog2(NPRED),
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [2:0]      op_kind,
  input  logic [PW-1:0]   op_guard,
  input  logic [PW-1:0]   op_pd1,
  input  logic [PW-1:0]   op_pd2,
  input  logic            op_cmp_res,
  input  logic [RW-1:0]   op_rd,
  input  logic            op_fault,
  input  logic [PC_W-1:0] op_fixup,
  output logic            out_fire,
  output logic            out_wen,
  output logic [RW-1:0]   out_wreg,
  output logic            out_exc,
  output logic            out_redir,
  output logic [PC_W-1:0] out_redir_pc,
  input  logic [PW-1:0]   pred_rd_idx,
  output logic            pred_rd_val,
  input  logic [RW-1:0]   psn_rd_idx,
  output logic            psn_rd_val
);
  import pq_pkg::*;

  op_kind_e kind;
  logic guard_ok, act;
  logic cmp_we, psn_upd, psn_val, psn_look;
  logic n_wen, n_exc, n_redir;

  assign op_ready = 1'b1;
  assign kind     = op_kind_e'(op_kind);
  assign act      = op_valid && guard_ok;

  pq_pred_file #(.NPRED(NPRED)) u_pred (
    .clk(clk), .rst_n(rst_n),
    .guard_idx(op_guard), .guard_ok(guard_ok),
    .we(cmp_we), .wa_a(op_pd1), .wd_a(op_cmp_res),
    .wa_b(op_pd2), .wd_b(~op_cmp_res),
    .rd_idx(pred_rd_idx), .rd_val(pred_rd_val)
  );

  pq_poison_file #(.NREG(NREG)) u_psn (
    .clk(clk), .rst_n(rst_n),
    .upd(psn_upd), .upd_idx(op_rd), .upd_val(psn_val),
    .look_idx(op_rd), .look_val(psn_look),
    .dbg_idx(psn_rd_idx), .dbg_val(psn_rd_val)
  );

  always_comb begin
    cmp_we  = 1'b0;
    psn_upd = 1'b0;
    psn_val = 1'b0;
    n_wen   = 1'b0;
    n_exc   = 1'b0;
    n_redir = 1'b0;
    if (act) begin
      unique case (kind)
        K_CMP: cmp_we = 1'b1;
        K_ALU: begin
          n_wen   = 1'b1;
          psn_upd = 1'b1;
        end
        K_LD: begin
          if (op_fault) n_exc = 1'b1;
          else begin
            n_wen   = 1'b1;
            psn_upd = 1'b1;
          end
        end
        K_LDS: begin
          n_wen   = 1'b1;
          psn_upd = 1'b1;
          psn_val = op_fault;
        end
        K_CHK: n_redir = psn_look;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_fire     <= 1'b0;
      out_wen      <= 1'b0;
      out_wreg     <= '0;
      out_exc      <= 1'b0;
      out_redir    <= 1'b0;
      out_redir_pc <= '0;
    end else begin
      out_fire     <= act;
      out_wen      <= n_wen;
      out_wreg     <= n_wen ? op_rd : '0;
      out_exc      <= n_exc;
      out_redir    <= n_redir;
      out_redir_pc <= n_redir ? op_fixup : '0;
    end
  end
endmodule

// File: rtl/pq_checker.sv
module pq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_ready,
  input logic [2:0] op_kind,
  input logic       guard_ok,
  input logic       out_fire,
  input logic       out_wen,
  input logic       out_exc,
  input logic       out_redir,
  input logic [5:0] pred_rd_idx,
  input logic       pred_rd_val
);
  assert_squash_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !guard_ok |=> !out_fire && !out_wen && !out_exc && !out_redir);
  assert_p0_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_rd_idx == 6'd0 |-> pred_rd_val);
  assert_exc_only_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_kind == 3'd3) |=> !out_exc);
  assert_redir_only_chk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_kind == 3'd5) |=> !out_redir);
  assert_always_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !out_fire && !out_wen);
  assert_exc_implies_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_exc |-> out_fire && !out_wen && !out_redir);
endmodule

bind pred_issue_unit pq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_kind(op_kind), .guard_ok(guard_ok), .out_fire(out_fire),
  .out_wen(out_wen), .out_exc(out_exc), .out_redir(out_redir),
  .pred_rd_idx(pred_rd_idx), .pred_rd_val(pred_rd_val)
);

// File: tb/pred_issue_unit_test.sv
module pred_issue_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready;
  logic [2:0] op_kind = '0;
  logic [5:0] op_guard = '0, op_pd1 = '0, op_pd2 = '0;
  logic op_cmp_res = 1'b0, op_fault = 1'b0;
  logic [4:0] op_rd = '0;
  logic [31:0] op_fixup = '0;
  logic out_fire, out_wen, out_exc, out_redir;
  logic [4:0] out_wreg;
  logic [31:0] out_redir_pc;
  logic [5:0] pred_rd_idx = '0;
  logic pred_rd_val;
  logic [4:0] psn_rd_idx = '0;
  logic psn_rd_val;

  int errors = 0, checks = 0;
  bit pm [64];
  bit zm [32];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  pred_issue_unit uut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic do_op(input int k, input int g, input int p1, input int p2,
                       input bit res, input int rd, input bit flt, input logic [31:0] pc);
    bit act, ewen, eexc, ered;
    @(negedge clk);
    op_valid = 1'b1; op_kind = 3'(k); op_guard = 6'(g); op_pd1 = 6'(p1);
    op_pd2 = 6'(p2); op_cmp_res = res; op_rd = 5'(rd); op_fault = flt; op_fixup = pc;
    act  = (g == 0) ? 1'b1 : pm[g];
    ewen = act && (k == 1 || (k == 3 && !flt) || k == 4);
    eexc = act && k == 3 && flt;
    ered = act && k == 5 && zm[rd];
    if (act) begin
      if (k == 2) begin
        if (p1 != 0) pm[p1] = res;
        if (p2 != 0) pm[p2] = !res;
      end
      if (k == 1 || (k == 3 && !flt)) zm[rd] = 1'b0;
      if (k == 4) zm[rd] = flt;
    end
    @(negedge clk);
    op_valid = 1'b0;
    chk("R9 fire", out_fire, act);
    chk(act ? "R7 wen" : "R4 wen", out_wen, ewen);
    if (ewen) chk("R5 wreg", out_wreg, rd);
    chk(k == 4 ? "R5 exc" : "R6 exc", out_exc, eexc);
    chk("R8 redir", out_redir, ered);
    if (ered) chk("R8 pc", out_redir_pc, pc);
    pred_rd_idx = 6'(p1); #1 chk("R2 pd1", pred_rd_val, pm[p1]);
    pred_rd_idx = 6'(p2); #1 chk("R2 pd2", pred_rd_val, pm[p2]);
    psn_rd_idx = 5'(rd);  #1 chk("R4 poison", psn_rd_val, zm[rd]);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (pm[i]) pm[i] = (i == 0);
    foreach (zm[i]) zm[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 64; i++) begin
      pred_rd_idx = 6'(i); #1 chk("R1 pred reset", pred_rd_val, i == 0);
    end
    for (int i = 0; i < 32; i++) begin
      psn_rd_idx = 5'(i); #1 chk("R1 poison reset", psn_rd_val, 1'b0);
    end
    chk("R9 ready", op_ready, 1'b1);
    chk("R1 outputs idle", {out_fire, out_wen, out_exc, out_redir}, 4'b0);
    // R3 writes to predicate 0 ignored
    do_op(2, 0, 0, 7, 1'b0, 0, 0, 0);
    do_op(2, 0, 9, 0, 1'b1, 0, 0, 0);
    pred_rd_idx = 0; #1 chk("R3 p0", pred_rd_val, 1'b1);
    // R2 same destination: inverse wins
    do_op(2, 0, 12, 12, 1'b1, 0, 0, 0);
    pred_rd_idx = 12; #1 chk("R2 same dest", pred_rd_val, 1'b0);
    // Near-exhaustive: kind x guard x fault x prior poison
    for (int k = 0; k < 8; k++)
      for (int gt = 0; gt < 2; gt++)
        for (int f = 0; f < 2; f++)
          for (int pz = 0; pz < 2; pz++) begin
            do_op(4, 0, 0, 0, 0, 5, bit'(pz), 0);
            do_op(2, 0, 10, 11, bit'(gt), 0, 0, 0);
            do_op(k, 10, 20 + k, 30 + k, bit'(f ^ pz), 5, bit'(f), 32'h8000_0000 + k);
            do_op(k, 11, 40, 41, 1'b1, 5, bit'(f), 32'h9000_0000 + k);
          end
    // Pseudo-random stress
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = rnd();
      do_op(int'(r[2:0]) % 6, (r[3] ? 0 : int'(r[9:4])), int'(r[15:10]), int'(r[21:16]),
            r[22], int'(r[27:23] & 5'h07), r[28], rnd());
    end
    for (int i = 0; i < 64; i++) begin
      pred_rd_idx = 6'(i); #1 chk("R2 final pred", pred_rd_val, pm[i]);
    end
    for (int i = 0; i < 32; i++) begin
      psn_rd_idx = 5'(i); #1 chk("R5 final poison", psn_rd_val, zm[i]);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule